// File: doc/BRIEF.md
# Segmented Time-Division Bus Arbiter

This block decides, cycle by cycle, which of several processors may drive a shared bus. The decision follows a schedule held in a small local table. The schedule is a time-ordered list of segments. Each segment has a start time, a length and a round. A round is an ordered list of slots, and each slot names one owning processor and a size in cycles. The round repeats back to back for as long as its segment lasts. The whole schedule begins again each time the period-start pulse arrives.

Software loads the table while the run enable is low. Raising the run enable and then pulsing period start launches the schedule from time zero. A processor raises its request line and keeps it raised. It receives its grant only while the current slot belongs to it. A request made in another processor's slot therefore waits until the requester's next slot begins.

Sequencer states: `ST_IDLE` (held, table writable), `ST_WAIT` (time runs, no owner, the next segment has not started), `ST_RUN` (a slot is active), `ST_DONE` (schedule exhausted, no owner until the next period start). Transitions:
- From any state, run enable low leads to `ST_IDLE`.
- With run enable high, period start leads to `ST_RUN` when segment 0 has slots and starts at 0, to `ST_WAIT` when it starts later, and to `ST_DONE` when it has no slots.
- `ST_RUN` leads to `ST_RUN` or `ST_WAIT` at the end of a segment, depending on the next segment's start.
- `ST_RUN` leads to `ST_DONE` when no further segment exists.
- `ST_WAIT` leads to `ST_RUN` on the cycle the time counter reaches the segment start.

Top module: `tdma_seg_arbiter`

## Requirements
- R1: The grant vector is one-hot or zero. Bit i is high only when processor i owns the active slot (`owner_vld` high, `owner_id` = i) and `req[i]` is high, in the same cycle. A slot whose owner is not requesting grants nobody.
- R2: Within a segment, the slots are taken in table order, starting at slot 0. Each slot lasts exactly its size in cycles. After the last slot of the round, the round repeats from slot 0.
- R3: When the time counter reaches segment start + length in the middle of a round, the round is cut off. On that cycle the next segment's slot 0 is active, provided that segment has started.
- R4: When the next segment's start lies after the current segment's end, no slot is active (`owner_vld` low) until the time counter equals that start. The same holds when segment 0 starts after time 0.
- R5: The schedule ends after the last table entry, or before any segment whose slot count is 0. From then on `owner_vld` stays low until the next period start.
- R6: With `run_en` high, a `period_start` pulse sets the time counter, the segment index and the slot index to 0 on the next cycle, even in the middle of a schedule.
- R7: One cycle after `run_en` is low, `owner_vld` is low and all grants are 0. A `period_start` seen while `run_en` is low has no effect. After `run_en` rises, the arbiter stays idle until a period start.
- R8: A table write takes effect only while `run_en` is low. `tbl_kind` selects the field:
  - 0 writes the segment start.
  - 1 writes the segment length.
  - 2 writes the slot count, saturated at NUM_CPU.
  - 3 writes slot `tbl_slot`, with the size in `tbl_data[7:0]` and the owner in `tbl_data[15:8]`. A slot word whose owner is ≥ NUM_CPU is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears the table |
| run_en | input | 1 | High lets the schedule run; low holds the arbiter idle |
| period_start | input | 1 | Pulse that restarts the schedule at time 0 |
| req | input | NUM_CPU | Per-processor request lines |
| tbl_we | input | 1 | Table write strobe |
| tbl_seg | input | SEG_W | Segment index for the write |
| tbl_kind | input | 2 | Field select for the write |
| tbl_slot | input | SLOT_W | Slot index for slot-word writes |
| tbl_data | input | TIME_W | Write data |
| gnt | output | NUM_CPU | One-hot grant |
| owner_id | output | OWN_W | Owner of the active slot |
| owner_vld | output | 1 | A slot is active |

## Verification
The slot state is registered, so the owner for time t is visible in the cycle after the edge that recorded time t. The first such cycle is the one directly after the edge that captured the period start. Grants depend combinationally on the request lines, so each grant check follows a request change within the same cycle. The bench drives its inputs at the falling edge and samples 2 ns later. It keeps its own time index, which starts at 0 in the cycle after the period-start edge. It compares owner and grant at every index against an owner computed arithmetically from its own copy of the schedule. Run-enable effects are checked one full cycle after the change.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2,
        ST_DONE = 2'd3
    } arb_state_t;

    localparam logic [1:0] KIND_START = 2'd0;
    localparam logic [1:0] KIND_LEN   = 2'd1;
    localparam logic [1:0] KIND_COUNT = 2'd2;
    localparam logic [1:0] KIND_SLOT  = 2'd3;
endpackage

// File: rtl/tdma_sched_table.sv
module tdma_sched_table #(
    parameter int NUM_CPU = 4,
    parameter int MAX_SEG = 8,
    parameter int TIME_W  = 16,
    parameter int SIZE_W  = 8,
    localparam int SEG_W  = $clog2(MAX_SEG),
    localparam int SLOT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int OWN_W  = SLOT_W,
    localparam int CNT_W  = $clog2(NUM_CPU + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_allow,
    input  logic              tbl_we,
    input  logic [SEG_W-1:0]  tbl_seg,
    input  logic [1:0]        tbl_kind,
    input  logic [SLOT_W-1:0] tbl_slot,
    input  logic [TIME_W-1:0] tbl_data,
    input  logic [SEG_W-1:0]  rd_seg,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [TIME_W-1:0] cur_start,
    output logic [TIME_W-1:0] cur_len,
    output logic [CNT_W-1:0]  cur_nslots,
    output logic [OWN_W-1:0]  cur_owner,
    output logic [SIZE_W-1:0] cur_size,
    output logic [TIME_W-1:0] nxt_start,
    output logic [CNT_W-1:0]  nxt_nslots,
    output logic [TIME_W-1:0] first_start,
    output logic [CNT_W-1:0]  first_nslots
);
    import tdma_pkg::*;

    localparam int OFLD_W = TIME_W - SIZE_W;

    logic [TIME_W-1:0] start_q  [MAX_SEG];
    logic [TIME_W-1:0] len_q    [MAX_SEG];
    logic [CNT_W-1:0]  nslots_q [MAX_SEG];
    logic [OWN_W-1:0]  own_q    [MAX_SEG][NUM_CPU];
    logic [SIZE_W-1:0] size_q   [MAX_SEG][NUM_CPU];

    logic              wr_fire;
    logic [OFLD_W-1:0] wr_owner_full;
    logic              wr_owner_ok;
    logic [CNT_W-1:0]  wr_count;
    logic [SEG_W-1:0]  nxt_seg;

    assign wr_fire       = tbl_we && wr_allow;
    assign wr_owner_full = tbl_data[TIME_W-1:SIZE_W];
    assign wr_owner_ok   = (wr_owner_full < OFLD_W'(NUM_CPU));
    assign wr_count      = (tbl_data > TIME_W'(NUM_CPU)) ? CNT_W'(NUM_CPU)
                                                         : CNT_W'(tbl_data);
    assign nxt_seg       = rd_seg + SEG_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < MAX_SEG; s++) begin
                start_q[s]  <= '0;
                len_q[s]    <= '0;
                nslots_q[s] <= '0;
                for (int k = 0; k < NUM_CPU; k++) begin
                    own_q[s][k]  <= '0;
                    size_q[s][k] <= '0;
                end
            end
        end else if (wr_fire) begin
            unique case (tbl_kind)
                KIND_START: start_q[tbl_seg]  <= tbl_data;
                KIND_LEN:   len_q[tbl_seg]    <= tbl_data;
                KIND_COUNT: nslots_q[tbl_seg] <= wr_count;
                KIND_SLOT: begin
                    if (wr_owner_ok) begin
                        own_q[tbl_seg][tbl_slot]  <= OWN_W'(wr_owner_full);
                        size_q[tbl_seg][tbl_slot] <= tbl_data[SIZE_W-1:0];
                    end
                end
            endcase
        end
    end

    assign cur_start    = start_q[rd_seg];
    assign cur_len      = len_q[rd_seg];
    assign cur_nslots   = nslots_q[rd_seg];
    assign cur_owner    = own_q[rd_seg][rd_slot];
    assign cur_size     = size_q[rd_seg][rd_slot];
    assign nxt_start    = start_q[nxt_seg];
    assign nxt_nslots   = nslots_q[nxt_seg];
    assign first_start  = start_q[0];
    assign first_nslots = nslots_q[0];

    // R8: while the table is locked, the entry being read stays fixed
    a_r8_table_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allow && $past(!wr_allow) && $stable(rd_seg) && $stable(rd_slot))
            |-> ($stable(cur_owner) && $stable(cur_size) && $stable(cur_start)));

    // R8: a slot count never exceeds the number of processors
    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cur_nslots <= CNT_W'(NUM_CPU));
endmodule

// File: rtl/tdma_sequencer.sv
module tdma_sequencer #(
    parameter int NUM_CPU = 4,
    parameter int MAX_SEG = 8,
    parameter int TIME_W  = 16,
    parameter int SIZE_W  = 8,
    localparam int SEG_W  = $clog2(MAX_SEG),
    localparam int SLOT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int CNT_W  = $clog2(NUM_CPU + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              period_start,
    input  logic [TIME_W-1:0] cur_start,
    input  logic [TIME_W-1:0] cur_len,
    input  logic [CNT_W-1:0]  cur_nslots,
    input  logic [SIZE_W-1:0] cur_size,
    input  logic [TIME_W-1:0] nxt_start,
    input  logic [CNT_W-1:0]  nxt_nslots,
    input  logic [TIME_W-1:0] first_start,
    input  logic [CNT_W-1:0]  first_nslots,
    output logic [SEG_W-1:0]  seg_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              owner_vld
);
    import tdma_pkg::*;

    arb_state_t        state_q, state_d;
    logic [TIME_W-1:0] t_q, t_d;
    logic [SEG_W-1:0]  seg_q, seg_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [SIZE_W-1:0] scnt_q, scnt_d;

    logic [TIME_W-1:0] t_inc;
    logic              seg_end_hit;
    logic              seg_last;
    logic              slot_done;
    logic              round_wrap;
    arb_state_t        launch_state;

    assign t_inc       = t_q + TIME_W'(1);
    assign seg_end_hit = (t_inc == cur_start + cur_len);
    assign seg_last    = (seg_q == SEG_W'(MAX_SEG - 1));
    assign slot_done   = (scnt_q + SIZE_W'(1) == cur_size);
    assign round_wrap  = (CNT_W'(slot_q) + CNT_W'(1) >= cur_nslots);

    always_comb begin
        if (first_nslots == '0)
            launch_state = ST_DONE;
        else if (first_start == '0)
            launch_state = ST_RUN;
        else
            launch_state = ST_WAIT;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            t_q     <= '0;
            seg_q   <= '0;
            slot_q  <= '0;
            scnt_q  <= '0;
        end else begin
            state_q <= state_d;
            t_q     <= t_d;
            seg_q   <= seg_d;
            slot_q  <= slot_d;
            scnt_q  <= scnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        t_d     = t_q;
        seg_d   = seg_q;
        slot_d  = slot_q;
        scnt_d  = scnt_q;
        if (!run_en) begin
            state_d = ST_IDLE;
        end else if (period_start) begin
            state_d = launch_state;
            t_d     = '0;
            seg_d   = '0;
            slot_d  = '0;
            scnt_d  = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_WAIT: begin
                    t_d = t_inc;
                    if (t_inc == cur_start)
                        state_d = ST_RUN;
                end
                ST_RUN: begin
                    t_d = t_inc;
                    if (seg_end_hit) begin
                        slot_d = '0;
                        scnt_d = '0;
                        if (seg_last || nxt_nslots == '0) begin
                            state_d = ST_DONE;
                        end else begin
                            seg_d   = seg_q + SEG_W'(1);
                            state_d = (nxt_start <= t_inc) ? ST_RUN : ST_WAIT;
                        end
                    end else if (slot_done) begin
                        scnt_d = '0;
                        slot_d = round_wrap ? '0 : slot_q + SLOT_W'(1);
                    end else begin
                        scnt_d = scnt_q + SIZE_W'(1);
                    end
                end
                ST_DONE: begin
                    state_d = ST_DONE;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        seg_idx   = seg_q;
        slot_idx  = slot_q;
        owner_vld = 1'b0;
        unique case (state_q)
            ST_IDLE: owner_vld = 1'b0;
            ST_WAIT: owner_vld = 1'b0;
            ST_RUN:  owner_vld = 1'b1;
            ST_DONE: owner_vld = 1'b0;
        endcase
    end

    // R6: a period start zeroes time, segment and slot
    a_r6_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && period_start) |=> (t_q == '0 && seg_q == '0 && slot_q == '0));

    // R7: a low run enable parks the sequencer
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == ST_IDLE && !owner_vld));

    // R2: the slot index never leaves the round
    a_r2_slot_in_round: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (CNT_W'(slot_q) < cur_nslots));

    // R4: waiting only happens before the segment's start
    a_r4_wait_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (t_q < cur_start));

    // R5: an exhausted schedule stays exhausted until restarted
    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && run_en && !period_start) |=> (state_q == ST_DONE));

    // R3: a segment change always restarts the round at slot 0
    a_r3_seg_change_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run_en && !period_start && seg_end_hit)
            |=> (slot_q == '0 && scnt_q == '0));
endmodule

// File: rtl/tdma_grant_gate.sv
module tdma_grant_gate #(
    parameter int NUM_CPU = 4,
    localparam int OWN_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CPU-1:0] req,
    input  logic [OWN_W-1:0]   owner_id,
    input  logic               owner_vld,
    output logic [NUM_CPU-1:0] gnt
);
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_lane
        always_comb begin
            gnt[i] = owner_vld && (owner_id == OWN_W'(i)) && req[i];
        end
    end

    // R1: never more than one grant
    a_r1_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R1: a grant implies an active slot with a requesting owner
    a_r1_gnt_needs_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0) |-> (owner_vld && req[owner_id]));
endmodule

// File: rtl/tdma_seg_arbiter.sv
module tdma_seg_arbiter #(
    parameter int NUM_CPU = 4,
    parameter int MAX_SEG = 8,
    parameter int TIME_W  = 16,
    parameter int SIZE_W  = 8,
    localparam int SEG_W  = $clog2(MAX_SEG),
    localparam int SLOT_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int OWN_W  = SLOT_W,
    localparam int CNT_W  = $clog2(NUM_CPU + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               period_start,
    input  logic [NUM_CPU-1:0] req,
    input  logic               tbl_we,
    input  logic [SEG_W-1:0]   tbl_seg,
    input  logic [1:0]         tbl_kind,
    input  logic [SLOT_W-1:0]  tbl_slot,
    input  logic [TIME_W-1:0]  tbl_data,
    output logic [NUM_CPU-1:0] gnt,
    output logic [OWN_W-1:0]   owner_id,
    output logic               owner_vld
);
    logic [SEG_W-1:0]  seg_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic [TIME_W-1:0] cur_start, cur_len, nxt_start, first_start;
    logic [CNT_W-1:0]  cur_nslots, nxt_nslots, first_nslots;
    logic [SIZE_W-1:0] cur_size;
    logic [OWN_W-1:0]  cur_owner;

    tdma_sched_table #(
        .NUM_CPU(NUM_CPU), .MAX_SEG(MAX_SEG), .TIME_W(TIME_W), .SIZE_W(SIZE_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .wr_allow(!run_en),
        .tbl_we(tbl_we), .tbl_seg(tbl_seg), .tbl_kind(tbl_kind),
        .tbl_slot(tbl_slot), .tbl_data(tbl_data),
        .rd_seg(seg_idx), .rd_slot(slot_idx),
        .cur_start(cur_start), .cur_len(cur_len), .cur_nslots(cur_nslots),
        .cur_owner(cur_owner), .cur_size(cur_size),
        .nxt_start(nxt_start), .nxt_nslots(nxt_nslots),
        .first_start(first_start), .first_nslots(first_nslots)
    );

    tdma_sequencer #(
        .NUM_CPU(NUM_CPU), .MAX_SEG(MAX_SEG), .TIME_W(TIME_W), .SIZE_W(SIZE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .period_start(period_start),
        .cur_start(cur_start), .cur_len(cur_len), .cur_nslots(cur_nslots),
        .cur_size(cur_size), .nxt_start(nxt_start), .nxt_nslots(nxt_nslots),
        .first_start(first_start), .first_nslots(first_nslots),
        .seg_idx(seg_idx), .slot_idx(slot_idx), .owner_vld(owner_vld)
    );

    assign owner_id = cur_owner;

    tdma_grant_gate #(.NUM_CPU(NUM_CPU)) u_gate (
        .clk(clk), .rst_n(rst_n), .req(req),
        .owner_id(owner_id), .owner_vld(owner_vld), .gnt(gnt)
    );
endmodule

// File: tb/sim_tdma_seg_arbiter.sv
module sim_tdma_seg_arbiter;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          period_start = 1'b0;
    logic [NC-1:0] req = '0;
    logic          tbl_we = 1'b0;
    logic [2:0]    tbl_seg = '0;
    logic [1:0]    tbl_kind = '0;
    logic [1:0]    tbl_slot = '0;
    logic [15:0]   tbl_data = '0;
    logic [NC-1:0] gnt;
    logic [1:0]    owner_id;
    logic          owner_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench copy of the schedule
    int m_start [8];
    int m_len   [8];
    int m_n     [8];
    int m_own   [8][4];
    int m_sz    [8][4];

    tdma_seg_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .period_start(period_start),
        .req(req), .tbl_we(tbl_we), .tbl_seg(tbl_seg), .tbl_kind(tbl_kind),
        .tbl_slot(tbl_slot), .tbl_data(tbl_data),
        .gnt(gnt), .owner_id(owner_id), .owner_vld(owner_vld)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_owner(input int t);
        int s = 0;
        while (s < 8 && m_n[s] != 0) begin
            if (t >= m_start[s] && t < m_start[s] + m_len[s]) begin
                int rl = 0;
                int off;
                for (int k = 0; k < m_n[s]; k++) rl += m_sz[s][k];
                off = (t - m_start[s]) % rl;
                for (int k = 0; k < m_n[s]; k++) begin
                    if (off < m_sz[s][k]) return m_own[s][k];
                    off -= m_sz[s][k];
                end
            end
            s++;
        end
        return -1;
    endfunction

    function automatic string tag_for(input int t);
        int e = exp_owner(t);
        if (e < 0 && t < 8) return "R4";
        if (e < 0 && t > 30) return "R5";
        if (e < 0) return "R4";
        if (t == 13 || t == 12) return "R3";
        return "R2";
    endfunction

    task automatic wr(input int seg, input int kind, input int slot, input int data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_seg = 3'(seg); tbl_kind = 2'(kind);
        tbl_slot = 2'(slot); tbl_data = 16'(data);
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic load_seg(input int s, input int st, input int ln, input int n);
        wr(s, 0, 0, st); wr(s, 1, 0, ln); wr(s, 2, 0, n);
        m_start[s] = st; m_len[s] = ln; m_n[s] = n;
    endtask

    task automatic load_slot(input int s, input int k, input int own, input int sz);
        wr(s, 3, k, (own << 8) | sz);
        m_own[s][k] = own; m_sz[s][k] = sz;
    endtask

    task automatic pulse_period();
        @(negedge clk); period_start = 1'b1;
        @(negedge clk); period_start = 1'b0;
    endtask

    // check one cycle at bench time t with request pattern rq (already at negedge)
    task automatic check_cycle(input int t, input logic [NC-1:0] rq, input string tg);
        int e;
        logic [NC-1:0] eg;
        req = rq;
        #2;
        e = exp_owner(t);
        chk(owner_vld == (e >= 0), tg, int'(owner_vld), int'(e >= 0));
        if (e >= 0) chk(owner_id == 2'(e), tg, int'(owner_id), e);
        eg = (e >= 0 && rq[e]) ? NC'(1 << e) : '0;
        chk(gnt == eg, {tg, "/R1"}, int'(gnt), int'(eg));
    endtask

    task automatic run_period(input int cycles, input int mode);
        pulse_period();
        for (int t = 0; t < cycles; t++) begin
            logic [NC-1:0] rq;
            if (t > 0) @(negedge clk);
            rq = (mode == 0) ? '1 : NC'((t * 5 + t / 3 + 1) & 15);
            check_cycle(t, rq, tag_for(t));
        end
    endtask

    initial begin
        for (int s = 0; s < 8; s++) begin
            m_start[s] = 0; m_len[s] = 0; m_n[s] = 0;
            for (int k = 0; k < 4; k++) begin m_own[s][k] = 0; m_sz[s][k] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        req = '1;
        #2;
        chk(owner_vld == 1'b0, "R7 reset owner_vld", int'(owner_vld), 0);
        chk(gnt == '0, "R7 reset gnt", int'(gnt), 0);

        // schedule A: cut mid-round at 13, gap 21..24, cut at 31, end
        load_seg(0, 0, 13, 2);  load_slot(0, 0, 1, 2); load_slot(0, 1, 2, 3);
        load_seg(1, 13, 8, 3);  load_slot(1, 0, 1, 2); load_slot(1, 1, 2, 2);
        load_slot(1, 2, 0, 1);
        load_seg(2, 25, 6, 2);  load_slot(2, 0, 3, 4); load_slot(2, 1, 0, 3);
        // R8: owner out of range is discarded
        wr(2, 3, 1, (7 << 8) | 9);

        @(negedge clk); run_en = 1'b1;
        repeat (3) @(negedge clk);
        #2;
        chk(owner_vld == 1'b0, "R7 idle until period start", int'(owner_vld), 0);

        run_period(36, 0);
        run_period(36, 1);

        // R6: restart in the middle of the schedule
        pulse_period();
        for (int t = 0; t < 9; t++) begin
            if (t > 0) @(negedge clk);
            check_cycle(t, '1, "R6 pre");
        end
        period_start = 1'b1;
        @(negedge clk); period_start = 1'b0;
        for (int t = 0; t < 8; t++) begin
            if (t > 0) @(negedge clk);
            check_cycle(t, '1, "R6 restart");
        end

        // R8: a write while running is ignored
        wr(0, 3, 0, (3 << 8) | 5);
        wr(0, 2, 0, 1);
        pulse_period();
        for (int t = 0; t < 14; t++) begin
            if (t > 0) @(negedge clk);
            check_cycle(t, '1, "R8 locked");
        end

        // R7: run_en low clears ownership; period start ignored
        @(negedge clk); run_en = 1'b0; req = '1;
        @(negedge clk); #2;
        chk(owner_vld == 1'b0, "R7 disabled owner_vld", int'(owner_vld), 0);
        chk(gnt == '0, "R7 disabled gnt", int'(gnt), 0);
        pulse_period();
        @(negedge clk); run_en = 1'b1;
        repeat (2) @(negedge clk); #2;
        chk(owner_vld == 1'b0, "R7 ignored period start", int'(owner_vld), 0);
        chk(gnt == '0, "R7 ignored period start gnt", int'(gnt), 0);

        // schedule B written while idle: late first segment, single segment
        @(negedge clk); run_en = 1'b0;
        load_seg(0, 2, 9, 3);   load_slot(0, 0, 0, 1); load_slot(0, 1, 3, 2);
        load_slot(0, 2, 2, 1);
        load_seg(1, 11, 4, 0);
        @(negedge clk); run_en = 1'b1;
        pulse_period();
        for (int t = 0; t < 15; t++) begin
            if (t > 0) @(negedge clk);
            check_cycle(t, '1, (t < 2) ? "R4 late start" : (t > 10) ? "R5 end" : "R8 new table");
        end
        pulse_period();
        for (int t = 0; t < 15; t++) begin
            if (t > 0) @(negedge clk);
            check_cycle(t, NC'((t * 3 + 2) & 15), "R1 sweep");
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule